// File: doc/BRIEF.md
# Reference divider with three-state phase detector

This block turns a stream of oscillator-rate enable strobes into a much slower reference strobe and compares that reference against feedback strobes coming from a programmable divider. First, a divide-by-two stage produces a half-rate strobe that is also exported, for example for a frequency multiplier. A counter then divides the half-rate strobe further. The total ratio is chosen by a select input: 1024 or 2048 oscillator strobes per reference strobe at the default size.

A two-flag phase-frequency detector tracks which of the two edges arrived first. It drives a correction output as a value plus an output enable, so the pin driver can float. The value is high when the feedback runs slow and low when it runs fast. The output is released when neither correction is pending.

A lock indicator is high while no correction is pending. It drops low for as long as the phase error lasts. Everything runs in one clock domain: edges are single-cycle strobes, and a synchronous reset clears the divider and both flags.

Top module: `refdiv_pfd`

## Requirements
- R1: `half_tick` is high only in a cycle where `osc_tick` is high. Counting `osc_tick` strobes from 0 after reset, it is high on every odd-numbered strobe (1, 3, 5, ...).
- R2: With `ratio_sel` = 1, `ref_tick` is high on oscillator strobe number k exactly when k mod P = P-1, where P = 2^LOG2_FAST (1024 by default).
- R3: With `ratio_sel` = 0, the same rule holds with P = 2^(LOG2_FAST+1) (2048 by default).
- R4: `ref_tick` is never high unless `half_tick` is high in the same cycle.
- R5: The raise flag is set in the cycle after `ref_tick`, and the lower flag in the cycle after `fb_strobe`. A set flag stays set until both flags are set.
- R6: In a cycle where both flags are set, both are cleared at the next edge. A `ref_tick` or `fb_strobe` arriving in that same cycle sets its flag again instead of being lost.
- R7: When only the raise flag is set (feedback slow), `corr_oe` = 1 and `corr_val` = 1.
- R8: When only the lower flag is set (feedback fast), `corr_oe` = 1 and `corr_val` = 0.
- R9: When neither flag is set, or both are, `corr_oe` = 0 and `corr_val` follows the raise flag.
- R10: `lock` = 1 exactly when neither flag is set. Its low pulse therefore spans from the first edge of a pair through the cycle in which both flags are set.
- R11: A synchronous reset (`rst` = 1 at a clock edge) clears both flags and restarts the oscillator strobe count at 0, giving `lock` = 1 and `corr_oe` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| osc_tick | input | 1 | Oscillator-rate enable strobe |
| ratio_sel | input | 1 | 1: total ratio 2^LOG2_FAST, 0: 2^(LOG2_FAST+1) |
| fb_strobe | input | 1 | Feedback strobe from the programmable divider |
| half_tick | output | 1 | Half-rate strobe tapped after the divide-by-two |
| ref_tick | output | 1 | Reference strobe at the end of the chain |
| corr_val | output | 1 | Correction drive value (1 raise, 0 lower) |
| corr_oe | output | 1 | Correction output enable; 0 means high impedance |
| lock | output | 1 | 1 while no phase error is pending |

## Verification
The in-line assertions check the following on every cycle:
- the half-rate and reference strobes only appear under an oscillator strobe and a half-rate strobe respectively;
- each strobe sets its flag on the next edge unless the pair is clearing;
- a full pair clears;
- an enabled drive and a high lock never coexist;
- reset leaves the detector idle.

Only the bench's sweeps can show the exact ratios for both select settings under sparse and dense oscillator patterns, and the re-arming of a strobe that lands in the clearing cycle. The same holds for the length of each lock pulse when the feedback leads, lags or coincides with the reference.

// File: rtl/refpfd_pkg.sv
package refpfd_pkg;

  typedef enum logic [1:0] {
    DRV_IDLE  = 2'b00,
    DRV_RAISE = 2'b01,
    DRV_LOWER = 2'b10,
    DRV_PAIR  = 2'b11
  } drv_state_e;

  // Oscillator strobes per reference strobe for a given select setting.
  function automatic int unsigned ref_period(input logic sel, input int unsigned log2_fast);
    return sel ? (32'd1 << log2_fast) : (32'd1 << (log2_fast + 1));
  endfunction

  // Last half-rate count before the reference strobe fires.
  function automatic int unsigned ref_half_limit(input logic sel, input int unsigned log2_fast);
    return (ref_period(sel, log2_fast) >> 1) - 1;
  endfunction

  function automatic drv_state_e classify(input logic up, input logic dn);
    return drv_state_e'({dn, up});
  endfunction

endpackage

// File: rtl/refpfd_halver.sv
module refpfd_halver (
  input  logic clk,
  input  logic rst,
  input  logic osc_tick,
  output logic half_tick
);

  logic phase_q;

  always_ff @(posedge clk) begin
    if (rst)           phase_q <= 1'b0;
    else if (osc_tick) phase_q <= ~phase_q;
  end

  assign half_tick = osc_tick & phase_q;

  p_half_needs_osc_r1: assert property (@(posedge clk) disable iff (rst)
    half_tick |-> osc_tick);

  p_half_alternates_r1: assert property (@(posedge clk) disable iff (rst)
    (half_tick && $past(osc_tick) && !$past(rst)) |-> !$past(half_tick));

endmodule

// File: rtl/refpfd_refchain.sv
module refpfd_refchain #(
  parameter int unsigned LOG2_FAST = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic half_tick,
  input  logic ratio_sel,
  output logic ref_tick
);

  localparam int unsigned CW = LOG2_FAST;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;
  logic          at_limit;

  assign limit    = CW'(refpfd_pkg::ref_half_limit(ratio_sel, LOG2_FAST));
  assign at_limit = (cnt_q >= limit);
  assign ref_tick = half_tick & at_limit;

  always_ff @(posedge clk) begin
    if (rst)            cnt_q <= '0;
    else if (ref_tick)  cnt_q <= '0;
    else if (half_tick) cnt_q <= cnt_q + 1'b1;
  end

  p_ref_under_half_r4: assert property (@(posedge clk) disable iff (rst)
    ref_tick |-> half_tick);

  p_ref_restarts_r2: assert property (@(posedge clk) disable iff (rst)
    ref_tick |=> (cnt_q == '0));

  p_count_holds_r3: assert property (@(posedge clk) disable iff (rst)
    !half_tick |=> $stable(cnt_q));

endmodule

// File: rtl/refpfd_detector.sv
module refpfd_detector (
  input  logic clk,
  input  logic rst,
  input  logic ref_tick,
  input  logic fb_strobe,
  output logic corr_val,
  output logic corr_oe,
  output logic lock
);
  import refpfd_pkg::*;

  logic       up_q;
  logic       dn_q;
  logic       pair_clear;
  drv_state_e state;

  assign pair_clear = up_q & dn_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else if (pair_clear) begin
      up_q <= ref_tick;
      dn_q <= fb_strobe;
    end else begin
      up_q <= up_q | ref_tick;
      dn_q <= dn_q | fb_strobe;
    end
  end

  assign state    = classify(up_q, dn_q);
  assign corr_oe  = (state == DRV_RAISE) || (state == DRV_LOWER);
  assign corr_val = (state == DRV_RAISE) || (state == DRV_PAIR);
  assign lock     = (state == DRV_IDLE);

  p_up_set_r5: assert property (@(posedge clk) disable iff (rst)
    (ref_tick && !pair_clear) |=> up_q);

  p_dn_set_r5: assert property (@(posedge clk) disable iff (rst)
    (fb_strobe && !pair_clear) |=> dn_q);

  p_pair_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (pair_clear && !ref_tick && !fb_strobe) |=> (!up_q && !dn_q));

  p_drive_not_locked_r10: assert property (@(posedge clk) disable iff (rst)
    corr_oe |-> !lock);

  p_reset_idle_r11: assert property (@(posedge clk)
    rst |=> (lock && !corr_oe));

endmodule

// File: rtl/refdiv_pfd.sv
module refdiv_pfd #(
  parameter int unsigned LOG2_FAST = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic osc_tick,
  input  logic ratio_sel,
  input  logic fb_strobe,
  output logic half_tick,
  output logic ref_tick,
  output logic corr_val,
  output logic corr_oe,
  output logic lock
);

  logic half_w;
  logic ref_w;

  refpfd_halver u_halver (
    .clk       (clk),
    .rst       (rst),
    .osc_tick  (osc_tick),
    .half_tick (half_w)
  );

  refpfd_refchain #(.LOG2_FAST(LOG2_FAST)) u_chain (
    .clk       (clk),
    .rst       (rst),
    .half_tick (half_w),
    .ratio_sel (ratio_sel),
    .ref_tick  (ref_w)
  );

  refpfd_detector u_det (
    .clk       (clk),
    .rst       (rst),
    .ref_tick  (ref_w),
    .fb_strobe (fb_strobe),
    .corr_val  (corr_val),
    .corr_oe   (corr_oe),
    .lock      (lock)
  );

  assign half_tick = half_w;
  assign ref_tick  = ref_w;

endmodule

// File: tb/refdiv_pfd_bench.sv
module refdiv_pfd_bench;

  localparam int L = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic osc_tick = 1'b0;
  logic ratio_sel = 1'b1;
  logic fb_strobe = 1'b0;
  logic half_tick, ref_tick, corr_val, corr_oe, lock;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  refdiv_pfd #(.LOG2_FAST(L)) u_refdiv_pfd (
    .clk(clk), .rst(rst), .osc_tick(osc_tick), .ratio_sel(ratio_sel),
    .fb_strobe(fb_strobe), .half_tick(half_tick), .ref_tick(ref_tick),
    .corr_val(corr_val), .corr_oe(corr_oe), .lock(lock)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; osc_tick = 1'b0; fb_strobe = 1'b0;
    @(negedge clk);
    #1;
    check(lock === 1'b1, "R11", "lock after reset", lock, 1);
    check(corr_oe === 1'b0, "R11", "corr_oe after reset", corr_oe, 0);
    check(half_tick === 1'b0, "R11", "half_tick idle", half_tick, 0);
    rst = 1'b0;
  endtask

  // osc_mode 0: every cycle, 1: every third cycle, 2: two on one off
  task automatic run_cfg(input logic sel, input int osc_mode, input int fb_per,
                         input int fb_off, input int ncyc);
    int  tick_idx = 0;
    int  period = 1 << (L + (sel ? 0 : 1));
    bit  eu = 0;
    bit  ed = 0;
    ratio_sel = sel;
    do_reset();
    for (int c = 0; c < ncyc; c++) begin
      bit o, f, e_half, e_ref;
      @(negedge clk);
      case (osc_mode)
        0: o = 1'b1;
        1: o = (c % 3 == 0);
        default: o = (c % 3 != 2);
      endcase
      f = (c % fb_per == fb_off);
      osc_tick = o; fb_strobe = f;
      #1;
      e_half = o && (tick_idx % 2 == 1);
      e_ref  = o && (tick_idx % period == period - 1);
      check(half_tick === e_half, "R1", "half_tick", half_tick, e_half);
      check(ref_tick === e_ref, sel ? "R2" : "R3", "ref_tick", ref_tick, e_ref);
      check(!(ref_tick && !half_tick), "R4", "ref without half", ref_tick, 0);
      if (eu && !ed) begin
        check(corr_oe === 1'b1 && corr_val === 1'b1, "R7", "raise oe/val",
              {corr_oe, corr_val}, 3);
      end else if (ed && !eu) begin
        check(corr_oe === 1'b1 && corr_val === 1'b0, "R8", "lower oe/val",
              {corr_oe, corr_val}, 2);
      end else begin
        check(corr_oe === 1'b0 && corr_val === eu, "R9", "idle oe/val",
              {corr_oe, corr_val}, {1'b0, eu});
      end
      check(lock === !(eu || ed), "R10", "lock (flags per R5/R6)", lock, !(eu || ed));
      if (eu && ed) begin
        eu = e_ref; ed = f;
      end else begin
        eu = eu || e_ref; ed = ed || f;
      end
      if (o) tick_idx++;
    end
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired (all requirements) actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int fb_pers[4] = '{6, 8, 11, 16};
    for (int s = 0; s < 2; s++) begin
      for (int m = 0; m < 3; m++) begin
        for (int k = 0; k < 4; k++) begin
          run_cfg(s[0], m, fb_pers[k], 7 % fb_pers[k], 150);
        end
      end
    end
    // Feedback strobe that never arrives: raise drive must persist (R7)
    run_cfg(1'b1, 0, 1000, 999, 60);
    // Feedback every cycle: lower flag re-arms in each clearing cycle (R6)
    run_cfg(1'b0, 0, 1, 0, 80);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule